// File: doc/BRIEF.md
# Two-Level Latched Interrupt Aggregator

This block gathers interrupt requests for a host-side peripheral bus controller and reduces them to one interrupt line. The first stage latches up to sixteen level-sensitive device interrupt lines, plus an internal event that reports a bus transfer that got no response. It holds a 32-bit status word, a mask word and a control word. A status bit stays set after its source goes away, until software clears it. A clear request on a device bit is refused while that device still drives its line high. An optional auto-clear mode drops a device status bit as soon as its line falls.

The second stage sees one summary input: "some first-stage interrupt is active". It has its own mask and a sticky status word. The single interrupt output is high whenever that sticky status is nonzero. A polarity word is kept for software but does not change any logic.

Software reaches every register through a plain single-cycle 32-bit register port. A write strobe with address and data is taken on the clock edge where it is seen, so the port never stalls and has no back-pressure. Read data is a combinational function of the address, and reads have no side effects.

Top module: `irq_latch_agg`

## Requirements
- R1: After reset every implemented register reads zero and `irq_out` is low.
- R2: A rising edge on device line n (n = 0..15) sets first-stage status bit 31-n on the next clock edge.
- R3: A falling device line leaves its status bit set when auto-clear is off.
- R4: Writing the first-stage status word at offset 0x38 clears exactly those bits that are written as one and whose device line is low at that edge. Bits written as zero, and bits whose line is high, keep their value.
- R5: When control bit 23 (auto-clear) is set and the `AUTOCLR_EN` parameter is 1, a falling device line clears its status bit.
- R6: The active set is status AND mask (offset 0x34). When control bit 31 (serial interrupt enable, control word at offset 0x30) is zero, bits 31..15 are removed from the active set. Bit 11 of the read-only second-stage input word (offset 0x5C) reads one exactly when the active set is nonzero, and writes to 0x5C have no effect.
- R7: A pulse on `bus_noresp` sets first-stage status bit 6 and captures `bus_noresp_addr` into the error-address word (offset 0x40). Writes to 0x40 have no effect.
- R8: Second-stage status (offset 0x50) ORs in the input word AND the mask (offset 0x54) on every edge. A write clears the bits written as one, but a bit whose masked input is still one stays set.
- R9: `irq_out` goes high one clock after second-stage status becomes nonzero and goes low one clock after it becomes zero.
- R10: The control word, both mask words and the polarity word (offset 0x58) read back as written, and the polarity word has no effect on `irq_out`. Any other word offset reads 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe, taken at the clock edge |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| dev_irq | input | N_DEV | Device interrupt lines, active high |
| bus_noresp | input | 1 | One-cycle pulse: a bus transfer got no response |
| bus_noresp_addr | input | 32 | Address of that transfer, captured with the pulse |
| irq_out | output | 1 | Registered aggregate interrupt |

## Verification
The bench targets the refused clear: it writes all ones to the status word while a device line is still high. A design that ignored the line level would drop the bit and lose a pending request. Each of the sixteen lines is swept through rise, refused clear, fall and accepted clear, with auto-clear off and then on. A swapped bit mapping, or auto-clear acting on the wrong edge, shows up as a wrong status word. The bench also checks the enable gate and the mask gate, the read-only input word, and the second-stage clear arriving while the summary input is still high (a wrong design loses the sticky bit). It counts the exact cycle where `irq_out` moves, so an extra or a missing register stage gives a failed check.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

  localparam int unsigned DW = 32;
  localparam int unsigned AW = 8;

  // register offsets (software-visible map)
  localparam logic [AW-1:0] OFS_DEV_CTRL = 8'h30;
  localparam logic [AW-1:0] OFS_DEV_MASK = 8'h34;
  localparam logic [AW-1:0] OFS_DEV_STAT = 8'h38;
  localparam logic [AW-1:0] OFS_DEV_ERRA = 8'h40;
  localparam logic [AW-1:0] OFS_MST_STAT = 8'h50;
  localparam logic [AW-1:0] OFS_MST_MASK = 8'h54;
  localparam logic [AW-1:0] OFS_MST_POL  = 8'h58;
  localparam logic [AW-1:0] OFS_MST_IN   = 8'h5C;

  // fixed bit positions
  localparam int unsigned CTRL_EN_BIT      = 31;
  localparam int unsigned CTRL_AUTOCLR_BIT = 23;
  localparam int unsigned NORESP_BIT       = 6;
  localparam int unsigned SUM_BIT          = 11;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_DEV_CTRL,
    SEL_DEV_MASK,
    SEL_DEV_STAT,
    SEL_DEV_ERRA,
    SEL_MST_STAT,
    SEL_MST_MASK,
    SEL_MST_POL,
    SEL_MST_IN
  } reg_sel_e;

  function automatic reg_sel_e decode_sel(input logic [AW-1:0] a);
    reg_sel_e s;
    case (a)
      OFS_DEV_CTRL: s = SEL_DEV_CTRL;
      OFS_DEV_MASK: s = SEL_DEV_MASK;
      OFS_DEV_STAT: s = SEL_DEV_STAT;
      OFS_DEV_ERRA: s = SEL_DEV_ERRA;
      OFS_MST_STAT: s = SEL_MST_STAT;
      OFS_MST_MASK: s = SEL_MST_MASK;
      OFS_MST_POL:  s = SEL_MST_POL;
      OFS_MST_IN:   s = SEL_MST_IN;
      default:      s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/irqagg_edge.sv
// Per-line edge detector: remembers the previous level of each line.
module irqagg_edge #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] level,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);

  for (genvar i = 0; i < N; i++) begin : g_line
    logic prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= level[i];
    end
    assign rise[i] = level[i] & ~prev_q;
    assign fall[i] = ~level[i] & prev_q;
  end

endmodule

// File: rtl/irqagg_dev_stage.sv
// First stage: latched device/error status, mask, control, error address.
module irqagg_dev_stage
  import irqagg_pkg::*;
#(
  parameter int unsigned N_DEV      = 16,
  parameter bit          AUTOCLR_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  reg_sel_e         sel,
  input  logic [DW-1:0]    wdata,
  input  logic [N_DEV-1:0] level,
  input  logic [N_DEV-1:0] rise,
  input  logic [N_DEV-1:0] fall,
  input  logic             noresp,
  input  logic [DW-1:0]    noresp_addr,
  output logic [DW-1:0]    stat,
  output logic [DW-1:0]    mask,
  output logic [DW-1:0]    ctrl,
  output logic [DW-1:0]    erra,
  output logic             any_active
);

  // device lines occupy the top N_DEV bits; one spare bit below them
  // belongs to the same enable-gated group
  localparam int unsigned GROUP_W = N_DEV + 1;
  localparam int unsigned DEV_LO  = DW - N_DEV;
  localparam logic [DW-1:0] DEV_GROUP = {{GROUP_W{1'b1}}, {(DW - GROUP_W){1'b0}}};

  logic [DW-1:0] lvl_map, rise_map, fall_map, err_set;
  logic [DW-1:0] stat_q, stat_d, mask_q, ctrl_q, erra_q;
  logic [DW-1:0] gate;

  // line n lands on bit DW-1-n
  for (genvar b = 0; b < DW; b++) begin : g_map
    if (b >= DEV_LO) begin : g_dev
      assign lvl_map[b]  = level[DW-1-b];
      assign rise_map[b] = rise[DW-1-b];
      assign fall_map[b] = fall[DW-1-b];
    end else begin : g_none
      assign lvl_map[b]  = 1'b0;
      assign rise_map[b] = 1'b0;
      assign fall_map[b] = 1'b0;
    end
  end

  always_comb begin
    err_set = '0;
    err_set[NORESP_BIT] = noresp;
  end

  // clears first, then new events, so a same-edge event always wins
  always_comb begin
    stat_d = stat_q;
    if (we && sel == SEL_DEV_STAT)
      stat_d = stat_d & ~(wdata & ~lvl_map);
    if (AUTOCLR_EN && ctrl_q[CTRL_AUTOCLR_BIT])
      stat_d = stat_d & ~fall_map;
    stat_d = stat_d | rise_map | err_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
      ctrl_q <= '0;
      erra_q <= '0;
    end else begin
      stat_q <= stat_d;
      if (we && sel == SEL_DEV_MASK) mask_q <= wdata;
      if (we && sel == SEL_DEV_CTRL) ctrl_q <= wdata;
      if (noresp)                    erra_q <= noresp_addr;
    end
  end

  assign gate       = ctrl_q[CTRL_EN_BIT] ? '1 : ~DEV_GROUP;
  assign any_active = |(stat_q & mask_q & gate);

  assign stat = stat_q;
  assign mask = mask_q;
  assign ctrl = ctrl_q;
  assign erra = erra_q;

endmodule

// File: rtl/irqagg_mst_stage.sv
// Second stage: summary input word, mask, sticky status, polarity, output.
module irqagg_mst_stage
  import irqagg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  reg_sel_e      sel,
  input  logic [DW-1:0] wdata,
  input  logic          sum_in,
  output logic [DW-1:0] in_vec,
  output logic [DW-1:0] stat,
  output logic [DW-1:0] mask,
  output logic [DW-1:0] pol,
  output logic          irq_out
);

  logic [DW-1:0] stat_q, stat_d, mask_q, pol_q, clr;
  logic          irq_q;

  always_comb begin
    in_vec = '0;
    in_vec[SUM_BIT] = sum_in;
  end

  assign clr    = (we && sel == SEL_MST_STAT) ? wdata : '0;
  assign stat_d = (stat_q & ~clr) | (in_vec & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
      pol_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      irq_q  <= |stat_q;
      if (we && sel == SEL_MST_MASK) mask_q <= wdata;
      if (we && sel == SEL_MST_POL)  pol_q  <= wdata;
    end
  end

  assign stat    = stat_q;
  assign mask    = mask_q;
  assign pol     = pol_q;
  assign irq_out = irq_q;

endmodule

// File: rtl/irqagg_rdmux.sv
// Read-data selection; unmapped offsets return all ones.
module irqagg_rdmux
  import irqagg_pkg::*;
(
  input  reg_sel_e      sel,
  input  logic [DW-1:0] dev_ctrl,
  input  logic [DW-1:0] dev_mask,
  input  logic [DW-1:0] dev_stat,
  input  logic [DW-1:0] dev_erra,
  input  logic [DW-1:0] mst_stat,
  input  logic [DW-1:0] mst_mask,
  input  logic [DW-1:0] mst_pol,
  input  logic [DW-1:0] mst_in,
  output logic [DW-1:0] rdata
);

  always_comb begin
    case (sel)
      SEL_DEV_CTRL: rdata = dev_ctrl;
      SEL_DEV_MASK: rdata = dev_mask;
      SEL_DEV_STAT: rdata = dev_stat;
      SEL_DEV_ERRA: rdata = dev_erra;
      SEL_MST_STAT: rdata = mst_stat;
      SEL_MST_MASK: rdata = mst_mask;
      SEL_MST_POL:  rdata = mst_pol;
      SEL_MST_IN:   rdata = mst_in;
      default:      rdata = '1;
    endcase
  end

endmodule

// File: rtl/irq_latch_agg.sv
module irq_latch_agg
  import irqagg_pkg::*;
#(
  parameter int unsigned N_DEV      = 16,
  parameter bit          AUTOCLR_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic [N_DEV-1:0] dev_irq,
  input  logic             bus_noresp,
  input  logic [DW-1:0]    bus_noresp_addr,
  output logic             irq_out
);

  reg_sel_e         sel;
  logic [N_DEV-1:0] dev_rise, dev_fall;
  logic [DW-1:0]    devs_stat, devs_mask, devs_ctrl, devs_erra;
  logic [DW-1:0]    mst_in, mst_stat, mst_mask, mst_pol;
  logic             any_active;

  assign sel = decode_sel(reg_addr);

  irqagg_edge #(.N(N_DEV)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .level (dev_irq),
    .rise  (dev_rise),
    .fall  (dev_fall)
  );

  irqagg_dev_stage #(.N_DEV(N_DEV), .AUTOCLR_EN(AUTOCLR_EN)) u_dev (
    .clk         (clk),
    .rst_n       (rst_n),
    .we          (reg_we),
    .sel         (sel),
    .wdata       (reg_wdata),
    .level       (dev_irq),
    .rise        (dev_rise),
    .fall        (dev_fall),
    .noresp      (bus_noresp),
    .noresp_addr (bus_noresp_addr),
    .stat        (devs_stat),
    .mask        (devs_mask),
    .ctrl        (devs_ctrl),
    .erra        (devs_erra),
    .any_active  (any_active)
  );

  irqagg_mst_stage u_mst (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (reg_we),
    .sel     (sel),
    .wdata   (reg_wdata),
    .sum_in  (any_active),
    .in_vec  (mst_in),
    .stat    (mst_stat),
    .mask    (mst_mask),
    .pol     (mst_pol),
    .irq_out (irq_out)
  );

  irqagg_rdmux u_rd (
    .sel      (sel),
    .dev_ctrl (devs_ctrl),
    .dev_mask (devs_mask),
    .dev_stat (devs_stat),
    .dev_erra (devs_erra),
    .mst_stat (mst_stat),
    .mst_mask (mst_mask),
    .mst_pol  (mst_pol),
    .mst_in   (mst_in),
    .rdata    (reg_rdata)
  );

endmodule

// File: rtl/irq_latch_agg_chk.sv
module irq_latch_agg_chk
  import irqagg_pkg::*;
#(
  parameter int unsigned N_DEV      = 16,
  parameter bit          AUTOCLR_EN = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [AW-1:0]    reg_addr,
  input logic [N_DEV-1:0] dev_wbits,
  input logic             sum_wbit,
  input logic [N_DEV-1:0] dev_irq,
  input logic             bus_noresp,
  input logic [DW-1:0]    devs_stat,
  input logic [DW-1:0]    devs_mask,
  input logic             ctrl_en,
  input logic             ctrl_autoclr,
  input logic             mst_sum,
  input logic [DW-1:0]    mst_stat,
  input logic             irq_out
);

  localparam int unsigned GROUP_W = N_DEV + 1;
  localparam logic [DW-1:0] DEV_GROUP = {{GROUP_W{1'b1}}, {(DW - GROUP_W){1'b0}}};

  logic wr_dev_stat, wr_mst_stat;
  assign wr_dev_stat = reg_we && (reg_addr == OFS_DEV_STAT);
  assign wr_mst_stat = reg_we && (reg_addr == OFS_MST_STAT);

  for (genvar i = 0; i < N_DEV; i++) begin : g_line
    AST_RISE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_irq[i] && !$past(dev_irq[i])) |=> devs_stat[DW-1-i]); // R2

    AST_HELD_NOT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_dev_stat && dev_wbits[N_DEV-1-i] && dev_irq[i] && devs_stat[DW-1-i])
      |=> devs_stat[DW-1-i]); // R4

    AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (devs_stat[DW-1-i] && !(wr_dev_stat && dev_wbits[N_DEV-1-i])
       && !(AUTOCLR_EN && ctrl_autoclr)) |=> devs_stat[DW-1-i]); // R3
  end

  AST_NORESP_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    bus_noresp |=> devs_stat[NORESP_BIT]); // R7

  AST_QUIET_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_en && ((devs_stat & devs_mask & ~DEV_GROUP) == '0)) |-> !mst_sum); // R6

  AST_MST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_stat[SUM_BIT] && !(wr_mst_stat && sum_wbit)) |=> mst_stat[SUM_BIT]); // R8

  AST_OUT_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_stat != '0) |=> irq_out); // R9

  AST_OUT_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_stat == '0) |=> !irq_out); // R9

endmodule

bind irq_latch_agg irq_latch_agg_chk #(.N_DEV(N_DEV), .AUTOCLR_EN(AUTOCLR_EN)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_we       (reg_we),
  .reg_addr     (reg_addr),
  .dev_wbits    (reg_wdata[irqagg_pkg::DW-1 -: N_DEV]),
  .sum_wbit     (reg_wdata[irqagg_pkg::SUM_BIT]),
  .dev_irq      (dev_irq),
  .bus_noresp   (bus_noresp),
  .devs_stat    (devs_stat),
  .devs_mask    (devs_mask),
  .ctrl_en      (devs_ctrl[irqagg_pkg::CTRL_EN_BIT]),
  .ctrl_autoclr (devs_ctrl[irqagg_pkg::CTRL_AUTOCLR_BIT]),
  .mst_sum      (mst_in[irqagg_pkg::SUM_BIT]),
  .mst_stat     (mst_stat),
  .irq_out      (irq_out)
);

// File: tb/sim_irq_latch_agg.sv
module sim_irq_latch_agg;
  import irqagg_pkg::*;

  localparam int unsigned N_DEV = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             reg_we = 1'b0;
  logic [AW-1:0]    reg_addr = '0;
  logic [DW-1:0]    reg_wdata = '0;
  logic [DW-1:0]    reg_rdata;
  logic [N_DEV-1:0] dev_irq = '0;
  logic             bus_noresp = 1'b0;
  logic [DW-1:0]    bus_noresp_addr = '0;
  logic             irq_out;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  irq_latch_agg #(.N_DEV(N_DEV), .AUTOCLR_EN(1'b1)) u0 (
    .clk             (clk),
    .rst_n           (rst_n),
    .reg_we          (reg_we),
    .reg_addr        (reg_addr),
    .reg_wdata       (reg_wdata),
    .reg_rdata       (reg_rdata),
    .dev_irq         (dev_irq),
    .bus_noresp      (bus_noresp),
    .bus_noresp_addr (bus_noresp_addr),
    .irq_out         (irq_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_we    = 1'b1;
    @(negedge clk);
    reg_we    = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    reg_addr = a;
    #1;
    check(tag, reg_rdata, exp);
  endtask

  task automatic set_dev(input int n, input logic v);
    dev_irq[n] = v;
    @(negedge clk);
  endtask

  task automatic pulse_noresp(input logic [DW-1:0] a);
    bus_noresp_addr = a;
    bus_noresp      = 1'b1;
    @(negedge clk);
    bus_noresp      = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  function automatic bit is_mapped(input int a);
    return a == 'h30 || a == 'h34 || a == 'h38 || a == 'h40 ||
           a == 'h50 || a == 'h54 || a == 'h58 || a == 'h5C;
  endfunction

  function automatic logic [31:0] dbit(input int n);
    return 32'h1 << (31 - n);
  endfunction

  initial begin
    #1_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog (all requirements) actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc();

    // R1: reset state
    rd_chk("R1 ctrl", OFS_DEV_CTRL, 32'h0);
    rd_chk("R1 mask", OFS_DEV_MASK, 32'h0);
    rd_chk("R1 stat", OFS_DEV_STAT, 32'h0);
    rd_chk("R1 erra", OFS_DEV_ERRA, 32'h0);
    rd_chk("R1 mst stat", OFS_MST_STAT, 32'h0);
    rd_chk("R1 mst mask", OFS_MST_MASK, 32'h0);
    rd_chk("R1 mst pol", OFS_MST_POL, 32'h0);
    rd_chk("R1 mst in", OFS_MST_IN, 32'h0);
    check("R1 irq_out", {31'b0, irq_out}, 32'h0);

    // R10: every unmapped word offset reads all ones
    for (int a = 0; a < 256; a += 4) begin
      if (!is_mapped(a)) rd_chk("R10 unmapped", a[7:0], 32'hFFFF_FFFF);
    end

    // R2/R3/R4: per-line sweep, auto-clear off
    for (int n = 0; n < N_DEV; n++) begin
      set_dev(n, 1'b1);
      rd_chk("R2 rise sets bit 31-n", OFS_DEV_STAT, dbit(n));
      wr(OFS_DEV_STAT, 32'hFFFF_FFFF);
      rd_chk("R4 clear refused while line high", OFS_DEV_STAT, dbit(n));
      set_dev(n, 1'b0);
      rd_chk("R3 fall keeps bit", OFS_DEV_STAT, dbit(n));
      wr(OFS_DEV_STAT, ~dbit(n));
      rd_chk("R4 zero-written bit kept", OFS_DEV_STAT, dbit(n));
      wr(OFS_DEV_STAT, dbit(n));
      rd_chk("R4 one-written low line cleared", OFS_DEV_STAT, 32'h0);
    end

    // R4: mixed clear, one line still high
    dev_irq = 16'h0021;
    cyc();
    rd_chk("R2 two lines", OFS_DEV_STAT, 32'h8400_0000);
    dev_irq[5] = 1'b0;
    cyc();
    wr(OFS_DEV_STAT, 32'hFFFF_FFFF);
    rd_chk("R4 partial clear", OFS_DEV_STAT, 32'h8000_0000);
    dev_irq = '0;
    cyc();
    wr(OFS_DEV_STAT, 32'hFFFF_FFFF);
    rd_chk("R4 final clear", OFS_DEV_STAT, 32'h0);

    // R5: auto-clear on
    wr(OFS_DEV_CTRL, 32'h0080_0000);
    rd_chk("R10 ctrl readback", OFS_DEV_CTRL, 32'h0080_0000);
    for (int n = 0; n < N_DEV; n++) begin
      set_dev(n, 1'b1);
      rd_chk("R5 rise with auto-clear", OFS_DEV_STAT, dbit(n));
      set_dev(n, 1'b0);
      rd_chk("R5 fall auto-clears", OFS_DEV_STAT, 32'h0);
    end
    wr(OFS_DEV_CTRL, 32'h0);

    // R7: no-response event
    pulse_noresp(32'h1234_5678);
    rd_chk("R7 noresp bit 6", OFS_DEV_STAT, 32'h0000_0040);
    rd_chk("R7 address captured", OFS_DEV_ERRA, 32'h1234_5678);
    wr(OFS_DEV_ERRA, 32'hFFFF_FFFF);
    rd_chk("R7 erra write ignored", OFS_DEV_ERRA, 32'h1234_5678);
    wr(OFS_DEV_STAT, 32'h0000_0040);
    rd_chk("R7 bit 6 cleared", OFS_DEV_STAT, 32'h0);

    // R6: active set and summary input
    wr(OFS_DEV_MASK, 32'hFFFF_FFFF);
    rd_chk("R10 mask readback", OFS_DEV_MASK, 32'hFFFF_FFFF);
    set_dev(3, 1'b1);
    rd_chk("R6 device bits gated by enable", OFS_MST_IN, 32'h0);
    wr(OFS_DEV_CTRL, 32'h8000_0000);
    rd_chk("R6 enabled summary", OFS_MST_IN, 32'h0000_0800);
    wr(OFS_MST_IN, 32'h0);
    rd_chk("R6 input word read-only", OFS_MST_IN, 32'h0000_0800);
    wr(OFS_DEV_MASK, 32'h1000_0000);
    rd_chk("R6 own mask bit", OFS_MST_IN, 32'h0000_0800);
    wr(OFS_DEV_MASK, 32'h0800_0000);
    rd_chk("R6 other mask bit", OFS_MST_IN, 32'h0);
    set_dev(3, 1'b0);
    wr(OFS_DEV_STAT, 32'hFFFF_FFFF);
    wr(OFS_DEV_CTRL, 32'h0);
    wr(OFS_DEV_MASK, 32'hFFFF_FFFF);
    pulse_noresp(32'h0000_0100);
    rd_chk("R6 error bit not gated", OFS_MST_IN, 32'h0000_0800);
    wr(OFS_DEV_STAT, 32'h0000_0040);
    rd_chk("R6 summary drops", OFS_MST_IN, 32'h0);
    check("R8 no second-stage mask no output", {31'b0, irq_out}, 32'h0);

    // R8/R9: second stage and output timing
    wr(OFS_MST_MASK, 32'h0000_0800);
    rd_chk("R10 mst mask readback", OFS_MST_MASK, 32'h0000_0800);
    pulse_noresp(32'h0000_0200);
    rd_chk("R8 not yet latched", OFS_MST_STAT, 32'h0);
    check("R9 output low at latch", {31'b0, irq_out}, 32'h0);
    cyc();
    rd_chk("R8 latched", OFS_MST_STAT, 32'h0000_0800);
    check("R9 output one cycle later", {31'b0, irq_out}, 32'h0);
    cyc();
    check("R9 output high", {31'b0, irq_out}, 32'h1);
    wr(OFS_MST_STAT, 32'hFFFF_FFFF);
    rd_chk("R8 set wins over clear", OFS_MST_STAT, 32'h0000_0800);
    wr(OFS_DEV_STAT, 32'h0000_0040);
    rd_chk("R6 input cleared", OFS_MST_IN, 32'h0);
    rd_chk("R8 sticky after input drops", OFS_MST_STAT, 32'h0000_0800);
    wr(OFS_MST_STAT, 32'h0000_0800);
    rd_chk("R8 clear accepted", OFS_MST_STAT, 32'h0);
    check("R9 output holds one cycle", {31'b0, irq_out}, 32'h1);
    cyc();
    check("R9 output falls", {31'b0, irq_out}, 32'h0);

    wr(OFS_MST_MASK, 32'h0);
    pulse_noresp(32'h0000_0300);
    cyc();
    cyc();
    rd_chk("R8 masked input", OFS_MST_IN, 32'h0000_0800);
    rd_chk("R8 masked not latched", OFS_MST_STAT, 32'h0);
    check("R8 masked output low", {31'b0, irq_out}, 32'h0);
    wr(OFS_DEV_STAT, 32'h0000_0040);

    // R10: polarity stored, no effect
    wr(OFS_MST_POL, 32'hFFFF_FFFF);
    rd_chk("R10 pol readback", OFS_MST_POL, 32'hFFFF_FFFF);
    cyc();
    cyc();
    check("R10 pol does not invert idle", {31'b0, irq_out}, 32'h0);
    wr(OFS_MST_MASK, 32'h0000_0800);
    pulse_noresp(32'h0000_0400);
    cyc();
    cyc();
    check("R10 pol does not invert active", {31'b0, irq_out}, 32'h1);

    finish_run();
  end

endmodule